// File: doc/BRIEF.md
# Time-of-Day Update Engine with Alarm

This block keeps the time of day as three bytes (seconds, minutes, hours) and moves it forward by one second for each 1 Hz tick it receives. The bytes are stored either as plain binary or as packed BCD, and hours run either as 0–23 or as 1–12 with a PM flag in the top bit. A tick does not change the time at once. It first raises an update-in-progress status for a fixed lead window. A fixed-length update window follows. At the end of that window the internal time steps forward, the host-visible copy is refreshed, and one-cycle pulses report the end of the update and any alarm match.

The host writes the time and alarm bytes through a simple write port. A write that lands inside the update window is parked in a one-entry slot and applied on the cycle after the window closes. An inhibit input freezes the host-visible copy, and the internal time keeps counting while it is set. Each of the three alarm bytes either has to equal its time byte or acts as a wildcard, so the alarm can repeat once a day, once an hour, once a minute or once a second.

Top module: `tod_engine`

## Requirements
- R1: After reset the visible seconds, minutes and hours bytes are 00h, and uip_o, upd_done_o and alarm_o are all 0.
- R2: A tick accepted while idle sets uip_o in the next cycle (unless inhibited). uip_o stays high for LEAD_CYC+UPD_CYC cycles and drops in the same cycle that upd_done_o rises.
- R3: upd_done_o is a single-cycle pulse that appears LEAD_CYC+UPD_CYC cycles after the clock edge that accepted the tick. Ticks that arrive while an update is pending are ignored.
- R4: While inhibit_i is 1, uip_o reads 0 and the visible time bytes do not change at an update, but the internal time still advances. The first update after inhibit_i returns to 0 shows the fully advanced time.
- R5: With binary_i=1, seconds and minutes count 00h..3Bh. Going from 3Bh to 00h carries into the next byte.
- R6: With binary_i=0 (BCD), a low nibble of 9 steps to 0 and the high nibble increments (09h→10h). Seconds and minutes go from 59h to 00h with a carry.
- R7: With h24_i=1, hours count 0–23 and go from 23 (17h binary, 23h BCD) to 00h.
- R8: With h24_i=0, bit 7 of the hours byte is the PM flag and bits 6:0 hold 1–12. Hour 12 steps to 1 with the flag kept. Hour 11 steps to 12 with the flag inverted (BCD 11h→92h, 91h→12h; binary 0Bh→8Ch).
- R9: alarm_o pulses together with upd_done_o when each of the new seconds, minutes and hours bytes equals its alarm byte.
- R10: An alarm byte with bits 7:6 equal to 11b matches any value of its time byte.
- R11: A write that is sampled while the update window is active is held. It is applied on the first edge after the window ends, so the update result is visible for one cycle before the written value.
- R12: Outside the update window, a write is applied at the sampling edge. Address 0/1/2 writes seconds/minutes/hours to both the internal and the visible copy, and address 4/5/6 writes the seconds/minutes/hours alarm byte. The visible bytes change only through a write or an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 Hz tick, one cycle wide |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Byte select: 0 sec, 1 min, 2 hr, 4/5/6 matching alarm bytes |
| wr_data_i | input | 8 | Host write data |
| binary_i | input | 1 | 1 = binary encoding, 0 = BCD |
| h24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| inhibit_i | input | 1 | Freezes the visible copy and masks uip_o |
| sec_o | output | 8 | Visible seconds byte |
| min_o | output | 8 | Visible minutes byte |
| hr_o | output | 8 | Visible hours byte |
| uip_o | output | 1 | Update-in-progress status |
| upd_done_o | output | 1 | One-cycle update-ended pulse |
| alarm_o | output | 1 | One-cycle alarm-match pulse |

## Verification
uip_o is due one cycle after the tick edge. upd_done_o, alarm_o and the refreshed time bytes are due LEAD_CYC+UPD_CYC edges after the tick edge, and the pulse is gone one edge later. A write applies at its own sampling edge, or, if held, one edge after the update result. The bench drives and samples only at falling edges and counts falling edges from the tick edge, so every comparison falls in the cycle the result is due. A reference model works from seconds-of-day integers, converts to the chosen encoding, and supplies the expected bytes and alarm decision.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  typedef logic [BYTE_W-1:0] tod_byte_t;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_ASEC = 3'd4;
  localparam logic [ADDR_W-1:0] A_AMIN = 3'd5;
  localparam logic [ADDR_W-1:0] A_AHR  = 3'd6;

  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_UPD} phase_e;

  typedef struct packed {
    tod_byte_t hr;
    tod_byte_t min;
    tod_byte_t sec;
  } tod_time_t;

  function automatic tod_byte_t digit_step(tod_byte_t v, logic bin);
    if (bin) return v + 8'd1;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic tod_byte_t sixty_lim(logic bin);
    return bin ? 8'h3B : 8'h59;
  endfunction

  function automatic tod_byte_t hour_step(tod_byte_t h, logic bin, logic h24);
    tod_byte_t twelve;
    tod_byte_t eleven;
    tod_byte_t tmp;
    twelve = bin ? 8'h0C : 8'h12;
    eleven = bin ? 8'h0B : 8'h11;
    if (h24) return (h == (bin ? 8'h17 : 8'h23)) ? 8'h00 : digit_step(h, bin);
    if (h[6:0] == twelve[6:0]) return {h[7], 7'd1};
    if (h[6:0] == eleven[6:0]) return {~h[7], twelve[6:0]};
    tmp = digit_step({1'b0, h[6:0]}, bin);
    return {h[7], tmp[6:0]};
  endfunction

  function automatic tod_time_t time_step(tod_time_t t, logic bin, logic h24);
    tod_time_t n;
    logic s_wrap;
    logic m_wrap;
    n      = t;
    s_wrap = (t.sec == sixty_lim(bin));
    m_wrap = (t.min == sixty_lim(bin));
    n.sec  = s_wrap ? 8'h00 : digit_step(t.sec, bin);
    if (s_wrap) begin
      n.min = m_wrap ? 8'h00 : digit_step(t.min, bin);
      if (m_wrap) n.hr = hour_step(t.hr, bin, h24);
    end
    return n;
  endfunction

  function automatic logic field_hit(tod_byte_t alarm, tod_byte_t now);
    return (alarm[7:6] == 2'b11) || (alarm == now);
  endfunction
endpackage

// File: rtl/tod_phase.sv
module tod_phase
  import tod_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned UPD_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  tod_byte_t         wr_data_i,
  output logic              fin_o,
  output logic              uip_o,
  output logic              done_o,
  output logic              apply_we_o,
  output logic [ADDR_W-1:0] apply_addr_o,
  output tod_byte_t         apply_data_o
);
  localparam int unsigned MAX_CYC = (LEAD_CYC > UPD_CYC) ? LEAD_CYC : UPD_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              uip_q;
  logic              done_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  tod_byte_t         pend_data_q;
  logic              in_upd;

  assign in_upd = (ph_q == PH_UPD);
  assign fin_o  = in_upd && (cnt_q == CNT_W'(UPD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      uip_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_o;
      unique case (ph_q)
        PH_IDLE: if (tick_i) begin
          ph_q  <= PH_LEAD;
          cnt_q <= '0;
          uip_q <= 1'b1;
        end
        PH_LEAD: begin
          if (cnt_q == CNT_W'(LEAD_CYC - 1)) begin
            ph_q  <= PH_UPD;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_UPD: begin
          if (fin_o) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            uip_q <= 1'b0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // one-entry hold slot for writes that hit the update window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (wr_en_i && (in_upd || pend_q)) begin
      pend_q      <= 1'b1;
      pend_addr_q <= wr_addr_i;
      pend_data_q <= wr_data_i;
    end else if (pend_q && !in_upd) begin
      pend_q <= 1'b0;
    end
  end

  assign apply_we_o   = !in_upd && (pend_q || wr_en_i);
  assign apply_addr_o = pend_q ? pend_addr_q : wr_addr_i;
  assign apply_data_o = pend_q ? pend_data_q : wr_data_i;
  assign uip_o        = uip_q;
  assign done_o       = done_q;
endmodule

// File: rtl/tod_time.sv
module tod_time
  import tod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  tod_byte_t         data_i,
  input  logic              fin_i,
  input  logic              binary_i,
  input  logic              h24_i,
  input  logic              inhibit_i,
  output tod_time_t         next_o,
  output tod_time_t         user_o
);
  tod_time_t core_q;
  tod_time_t user_q;

  assign next_o = time_step(core_q, binary_i, h24_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q <= '0;
      user_q <= '0;
    end else if (fin_i) begin
      core_q <= next_o;
      if (!inhibit_i) user_q <= next_o;
    end else if (we_i) begin
      unique case (addr_i)
        A_SEC: begin core_q.sec <= data_i; user_q.sec <= data_i; end
        A_MIN: begin core_q.min <= data_i; user_q.min <= data_i; end
        A_HR:  begin core_q.hr  <= data_i; user_q.hr  <= data_i; end
        default: ;
      endcase
    end
  end

  assign user_o = user_q;
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  tod_byte_t         data_i,
  input  logic              fin_i,
  input  tod_time_t         now_i,
  output logic              alarm_o
);
  tod_time_t alm_q;
  logic      alarm_q;
  logic      all_hit;

  assign all_hit = field_hit(alm_q.sec, now_i.sec) &&
                   field_hit(alm_q.min, now_i.min) &&
                   field_hit(alm_q.hr,  now_i.hr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= fin_i && all_hit;
      if (we_i) begin
        unique case (addr_i)
          A_ASEC: alm_q.sec <= data_i;
          A_AMIN: alm_q.min <= data_i;
          A_AHR:  alm_q.hr  <= data_i;
          default: ;
        endcase
      end
    end
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/tod_engine.sv
module tod_engine
  import tod_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned UPD_CYC  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       binary_i,
  input  logic       h24_i,
  input  logic       inhibit_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic       uip_o,
  output logic       upd_done_o,
  output logic       alarm_o
);
  logic              fin;
  logic              uip_raw;
  logic              apply_we;
  logic [ADDR_W-1:0] apply_addr;
  tod_byte_t         apply_data;
  tod_time_t         next_time;
  tod_time_t         user_time;

  tod_phase #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) i_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .fin_o       (fin),
    .uip_o       (uip_raw),
    .done_o      (upd_done_o),
    .apply_we_o  (apply_we),
    .apply_addr_o(apply_addr),
    .apply_data_o(apply_data)
  );

  tod_time i_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (apply_we),
    .addr_i   (apply_addr),
    .data_i   (apply_data),
    .fin_i    (fin),
    .binary_i (binary_i),
    .h24_i    (h24_i),
    .inhibit_i(inhibit_i),
    .next_o   (next_time),
    .user_o   (user_time)
  );

  tod_alarm i_alarm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (apply_we),
    .addr_i (apply_addr),
    .data_i (apply_data),
    .fin_i  (fin),
    .now_i  (next_time),
    .alarm_o(alarm_o)
  );

  assign uip_o = uip_raw & ~inhibit_i;
  assign sec_o = user_time.sec;
  assign min_o = user_time.min;
  assign hr_o  = user_time.hr;
endmodule

// File: rtl/tod_engine_chk.sv
module tod_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       inhibit_i,
  input logic       apply_we,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hr_o,
  input logic       uip_o,
  input logic       upd_done_o,
  input logic       alarm_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |=> !upd_done_o); // R3

  AST_UIP_DROPS_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |-> !uip_o); // R2

  AST_UIP_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_done_o && !$past(inhibit_i)) |-> $past(uip_o)); // R2

  AST_USER_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_done_o && $past(inhibit_i) && !$past(apply_we)) |->
      ($stable(sec_o) && $stable(min_o) && $stable(hr_o))); // R4

  AST_ALARM_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> upd_done_o); // R9

  AST_USER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_done_o && !$past(apply_we)) |->
      ($stable(sec_o) && $stable(min_o) && $stable(hr_o))); // R12
endmodule

bind tod_engine tod_engine_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .inhibit_i (inhibit_i),
  .apply_we  (apply_we),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hr_o      (hr_o),
  .uip_o     (uip_o),
  .upd_done_o(upd_done_o),
  .alarm_o   (alarm_o)
);

// File: tb/test_tod_engine.sv
`timescale 1ns/1ps
module test_tod_engine;
  localparam int L = 4;
  localparam int U = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       bin = 1'b0;
  logic       h24 = 1'b1;
  logic       inhibit = 1'b0;
  logic [7:0] sec, min, hr;
  logic       uip, done, alarm;

  int checks = 0;
  int errors = 0;
  int tsec = 0;
  logic [7:0] eu_s = 8'h00, eu_m = 8'h00, eu_h = 8'h00;
  logic [7:0] al_s = 8'h00, al_m = 8'h00, al_h = 8'h00;

  always #4 clk = ~clk;

  tod_engine #(.LEAD_CYC(L), .UPD_CYC(U)) i_tod_engine (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .binary_i(bin), .h24_i(h24),
    .inhibit_i(inhibit), .sec_o(sec), .min_o(min), .hr_o(hr),
    .uip_o(uip), .upd_done_o(done), .alarm_o(alarm)
  );

  function automatic logic [7:0] enc(int n, bit b);
    if (b) return 8'(n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic [7:0] enc_hr(int h, bit b, bit f24);
    logic [7:0] e;
    int h12;
    if (f24) return enc(h, b);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    e = enc(h12, b);
    return {(h >= 12) ? 1'b1 : 1'b0, e[6:0]};
  endfunction

  function automatic bit hit(logic [7:0] a, logic [7:0] now);
    return (a[7:6] == 2'b11) || (a == now);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(int t);
    tsec = t;
    eu_s = enc(t % 60, bin);
    eu_m = enc((t / 60) % 60, bin);
    eu_h = enc_hr(t / 3600, bin, h24);
    wr(3'd0, eu_s);
    wr(3'd1, eu_m);
    wr(3'd2, eu_h);
  endtask

  task automatic set_alarm(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    al_s = s; al_m = m; al_h = h;
    wr(3'd4, s);
    wr(3'd5, m);
    wr(3'd6, h);
  endtask

  task automatic run_update(bit retick);
    logic [7:0] ns, nm, nh;
    bit exp_al;
    string rq_ms, rq_h, rq_al;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R2 uip after tick", uip, !inhibit);
    if (retick) tick = 1'b1;
    for (int i = 1; i < L + U; i++) begin
      @(negedge clk); tick = 1'b0;
    end
    chk("R2 uip held", uip, !inhibit);
    chk("R3 done not early", done, 1'b0);
    @(negedge clk);
    tsec = (tsec + 1) % 86400;
    ns = enc(tsec % 60, bin);
    nm = enc((tsec / 60) % 60, bin);
    nh = enc_hr(tsec / 3600, bin, h24);
    if (!inhibit) begin eu_s = ns; eu_m = nm; eu_h = nh; end
    exp_al = hit(al_s, ns) && hit(al_m, nm) && hit(al_h, nh);
    rq_ms = inhibit ? "R4 frozen" : (bin ? "R5 bin" : "R6 bcd");
    rq_h  = inhibit ? "R4 frozen" : (h24 ? "R7 24h" : "R8 12h");
    rq_al = ((al_s[7:6] == 2'b11) || (al_m[7:6] == 2'b11) || (al_h[7:6] == 2'b11)) ? "R10 wildcard" : "R9 alarm";
    chk("R3 done pulse", done, 1'b1);
    chk("R2 uip cleared", uip, 1'b0);
    chk(rq_ms, {min, sec}, {eu_m, eu_s});
    chk(rq_h, hr, eu_h);
    chk(rq_al, alarm, exp_al);
    @(negedge clk);
    chk("R3 done one cycle", done, 1'b0);
    if (retick) chk("R3 extra tick ignored", uip, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", {hr, min, sec}, 24'h0);
    chk("R1 flags", {uip, done, alarm}, 3'b000);

    // binary 24h full rollover with matching alarm
    bin = 1'b1; h24 = 1'b1;
    set_time(86399);
    chk("R12 write visible", {hr, min, sec}, {8'h17, 8'h3B, 8'h3B});
    set_alarm(8'h00, 8'h00, 8'h00);
    run_update(1'b0);
    chk("R5 R7 rollover", {hr, min, sec}, 24'h0);

    // BCD nibble carry and 24h hour carry
    bin = 1'b0;
    set_time(9);
    set_alarm(8'h11, 8'h00, 8'h00);
    run_update(1'b0);
    chk("R6 nibble", sec, 8'h10);
    set_time(23 * 3600 + 3599);
    run_update(1'b0);
    chk("R7 bcd 23", hr, 8'h00);

    // 12h BCD transitions
    h24 = 1'b0;
    set_time(11 * 3600 + 3599);
    run_update(1'b0);
    chk("R8 11am to 12pm", hr, 8'h92);
    set_time(12 * 3600 + 3599);
    run_update(1'b0);
    chk("R8 12pm to 1pm", hr, 8'h81);
    set_time(23 * 3600 + 3599);
    run_update(1'b0);
    chk("R8 11pm to 12am", hr, 8'h12);
    bin = 1'b1;
    set_time(11 * 3600 + 3599);
    run_update(1'b0);
    chk("R8 bin 11am", hr, 8'h8C);

    // wildcards
    bin = 1'b0; h24 = 1'b1;
    set_time(5 * 3600 + 7 * 60 + 30);
    set_alarm(8'h31, 8'hC5, 8'hFF);
    run_update(1'b0);
    set_alarm(8'h32, 8'h07, 8'h05);
    run_update(1'b0);

    // inhibit: visible frozen, internal keeps counting
    set_time(100);
    @(negedge clk); inhibit = 1'b1;
    @(negedge clk);
    chk("R4 uip masked idle", uip, 1'b0);
    run_update(1'b0);
    run_update(1'b0);
    chk("R4 still frozen", sec, enc(100 % 60, bin));
    @(negedge clk); inhibit = 1'b0;
    run_update(1'b0);
    chk("R4 catches up", {min, sec}, {enc(1, bin), enc(43, bin)});

    // write held during update window
    set_time(200);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    for (int i = 0; i < L; i++) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h45;
    @(negedge clk); wr_en = 1'b0;
    for (int i = 0; i < U - 1; i++) @(negedge clk);
    chk("R11 done with held write", done, 1'b1);
    chk("R11 update first", sec, enc(21, bin));
    @(negedge clk);
    chk("R11 held write applied", sec, 8'h45);
    tsec = 3 * 60 + 45;
    eu_s = 8'h45; eu_m = enc(3, bin); eu_h = 8'h00;
    run_update(1'b0);
    chk("R11 internal took write", sec, 8'h46);

    // extra tick during pending update
    run_update(1'b1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      int t, sel;
      logic [7:0] ns, nm, nh;
      bin = 1'($urandom);
      h24 = 1'($urandom);
      sel = $urandom % 4;
      case (sel)
        0: t = $urandom % 86400;
        1: t = ($urandom % 24) * 3600 + 3599;
        2: t = ($urandom % 1440) * 60 + 59;
        default: t = ($urandom % 8640) * 10 + 9;
      endcase
      set_time(t);
      ns = enc((t + 1) % 86400 % 60, bin);
      nm = enc(((t + 1) % 86400 / 60) % 60, bin);
      nh = enc_hr((t + 1) % 86400 / 3600, bin, h24);
      if ($urandom % 2) set_alarm(($urandom % 3 == 0) ? 8'hC0 : ns,
                                  ($urandom % 3 == 0) ? 8'hD3 : nm,
                                  ($urandom % 3 == 0) ? 8'hFE : nh);
      else set_alarm(enc($urandom % 60, bin), nm, nh);
      run_update(1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule